// File: doc/BRIEF.md
# Reference-Bit Victim Selector

This block picks which physical frame to evict when memory is full. It keeps one reference bit per frame and nothing else: no timestamps, no ordering queue. Every reported access to a frame sets that frame's bit. When a victim is requested, a pointer walks the frames one per clock. A frame whose bit is 1 has had a recent access, so it is passed over and its bit is cleared. The first frame found with its bit at 0 is offered as the victim.

Requests come in on a valid/ready pair. `req_ready` is high only while the block is idle, and a request is taken on a cycle where `req_valid` and `req_ready` are both high. The result goes out on a second valid/ready pair. `vic_valid` stays high, with `vic_frame` held still, until the consumer raises `vic_ready`. No new request is taken while a result is waiting, so a slow consumer stalls the selector. Access reports are a plain strobe with a frame index and are never back-pressured. They are taken in every state.

When a result is handed over, the victim's bit is set, because the frame is about to be refilled. The next walk starts at the frame after the victim and wraps around after the last frame.

Top module: `ref_victim_sel`

## Requirements
- R1: After reset all reference bits are 0, the pointer is at frame 0, `req_ready` is 1 and `vic_valid` is 0. The first request after reset therefore yields frame 0, with `vic_valid` rising one clock after the accepting edge.
- R2: A cycle with `acc_valid` high sets the bit of frame `acc_frame` to 1 at the next edge. A later walk then passes over that frame instead of choosing it.
- R3: During a walk, the frame under the pointer is chosen as victim when its bit is 0 and no access to it is reported in that same cycle. `vic_frame` then shows that frame index.
- R4: During a walk, a frame whose bit is 1 is not chosen and its bit is cleared to 0. A second pass over it will choose it unless it is accessed again.
- R5: A walk starts at the frame after the last handed-over victim. After frame N-1 (with N = 64 by default) it continues at frame 0.
- R6: The walk examines exactly one frame per clock. With no access reported during the walk, `vic_valid` rises at most N+1 clocks after the accepting edge. When every bit is 1, it rises at exactly N+1 clocks.
- R7: If an access report and a walk's clear hit the same frame in the same cycle, the access wins. That frame's bit stays 1 and the frame is passed over.
- R8: On the handover cycle (`vic_valid` and `vic_ready` both high), the victim's bit is set to 1. `req_ready` returns to 1 one clock later.
- R9: While `vic_valid` is high and `vic_ready` is low, `vic_valid` stays high, `vic_frame` stays stable and `req_ready` stays 0, whatever `req_valid` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access report strobe |
| acc_frame | input | IDX_W (6) | Frame index of the reported access |
| req_valid | input | 1 | Victim request valid |
| req_ready | output | 1 | Selector idle and able to take a request |
| vic_valid | output | 1 | Victim result valid |
| vic_ready | input | 1 | Consumer takes the victim result |
| vic_frame | output | IDX_W (6) | Index of the chosen victim frame |

## Verification
A wrong reference bit cannot be read directly. It shows up as a different `vic_frame`, or as the walk taking a different number of clocks to raise `vic_valid`. A set bit that was not cleared moves the victim by one or more frames in the next walk. A lost access report brings the victim forward. A wrong pointer shifts the very next victim. Directed cases that fill every bit and force a full wrap make such an error appear within one request, at a clock count that can be predicted exactly. A reference model running beside the block compares the handshake outputs on every clock of a long random run.

// File: rtl/ref_vsel_pkg.sv
package ref_vsel_pkg;
  typedef enum logic [1:0] {
    VS_IDLE = 2'd0,
    VS_SCAN = 2'd1,
    VS_HOLD = 2'd2
  } vsel_state_e;
endpackage

// File: rtl/ref_bit_array.sv
module ref_bit_array #(
  parameter int NUM_FRAMES = 64,
  parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc_valid,
  input  logic [IDX_W-1:0]      acc_frame,
  input  logic                  clr_en,
  input  logic [IDX_W-1:0]      clr_idx,
  input  logic                  set_en,
  input  logic [IDX_W-1:0]      set_idx,
  output logic [NUM_FRAMES-1:0] ref_bits
);

  // One flop per frame; a set (access or handover) beats a walk clear.
  for (genvar f = 0; f < NUM_FRAMES; f++) begin : g_frame
    logic hit_set;
    logic hit_clr;
    assign hit_set = (acc_valid && (acc_frame == IDX_W'(f))) ||
                     (set_en && (set_idx == IDX_W'(f)));
    assign hit_clr = clr_en && (clr_idx == IDX_W'(f));

    always_ff @(posedge clk) begin
      if (!rst_n)       ref_bits[f] <= 1'b0;
      else if (hit_set) ref_bits[f] <= 1'b1;
      else if (hit_clr) ref_bits[f] <= 1'b0;
    end
  end

  AST_ACC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> ref_bits[$past(acc_frame)]); // R2

  AST_ACC_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && acc_valid && (acc_frame == clr_idx)) |=> ref_bits[$past(clr_idx)]); // R7

  AST_PASS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !(acc_valid && (acc_frame == clr_idx)) && !(set_en && (set_idx == clr_idx)))
      |=> !ref_bits[$past(clr_idx)]); // R4

  AST_GRANT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> ref_bits[$past(set_idx)]); // R8

endmodule

// File: rtl/ref_scan_ctrl.sv
module ref_scan_ctrl
  import ref_vsel_pkg::*;
#(
  parameter int NUM_FRAMES = 64,
  parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_FRAMES-1:0] ref_bits,
  input  logic                  acc_valid,
  input  logic [IDX_W-1:0]      acc_frame,
  input  logic                  req_valid,
  output logic                  req_ready,
  output logic                  vic_valid,
  input  logic                  vic_ready,
  output logic [IDX_W-1:0]      vic_frame,
  output logic                  clr_en,
  output logic [IDX_W-1:0]      clr_idx,
  output logic                  set_en,
  output logic [IDX_W-1:0]      set_idx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_FRAMES - 1);
  localparam int               LEN_W    = IDX_W + 2;

  vsel_state_e      st;
  logic [IDX_W-1:0] ptr;
  logic [IDX_W-1:0] vic_q;
  logic             cur_hot;

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] i);
    return (i == LAST_IDX) ? '0 : i + 1'b1;
  endfunction

  // Frame under the pointer counts as referenced if its bit is set or
  // an access to it arrives in this very cycle.
  assign cur_hot = ref_bits[ptr] | (acc_valid && (acc_frame == ptr));

  always_comb begin
    clr_en  = (st == VS_SCAN) && cur_hot;
    clr_idx = ptr;
    set_en  = (st == VS_HOLD) && vic_ready;
    set_idx = vic_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= VS_IDLE;
      ptr   <= '0;
      vic_q <= '0;
    end else begin
      unique case (st)
        VS_IDLE: if (req_valid) st <= VS_SCAN;
        VS_SCAN: begin
          if (!cur_hot) begin
            vic_q <= ptr;
            st    <= VS_HOLD;
          end else begin
            ptr <= step(ptr);
          end
        end
        VS_HOLD: begin
          if (vic_ready) begin
            ptr <= step(vic_q);
            st  <= VS_IDLE;
          end
        end
        default: st <= VS_IDLE;
      endcase
    end
  end

  assign req_ready = (st == VS_IDLE);
  assign vic_valid = (st == VS_HOLD);
  assign vic_frame = vic_q;

  // Walk-length monitor for the sweep bound.
  logic [LEN_W-1:0] scan_len;
  logic             noisy;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scan_len <= '0;
      noisy    <= 1'b0;
    end else if (st == VS_IDLE) begin
      scan_len <= '0;
      noisy    <= 1'b0;
    end else if (st == VS_SCAN) begin
      scan_len <= scan_len + 1'b1;
      noisy    <= noisy | acc_valid;
    end
  end

  AST_SWEEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == VS_SCAN) && !noisy && !acc_valid) |-> (scan_len <= LEN_W'(NUM_FRAMES))); // R6

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_valid && !vic_ready) |=> (vic_valid && $stable(vic_frame) && !req_ready)); // R9

endmodule

// File: rtl/ref_victim_sel.sv
module ref_victim_sel #(
  parameter int NUM_FRAMES = 64,
  parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [IDX_W-1:0] acc_frame,
  input  logic             req_valid,
  output logic             req_ready,
  output logic             vic_valid,
  input  logic             vic_ready,
  output logic [IDX_W-1:0] vic_frame
);

  logic [NUM_FRAMES-1:0] ref_bits;
  logic                  clr_en;
  logic [IDX_W-1:0]      clr_idx;
  logic                  set_en;
  logic [IDX_W-1:0]      set_idx;

  ref_bit_array #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_bits (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_frame (acc_frame),
    .clr_en    (clr_en),
    .clr_idx   (clr_idx),
    .set_en    (set_en),
    .set_idx   (set_idx),
    .ref_bits  (ref_bits)
  );

  ref_scan_ctrl #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_bits  (ref_bits),
    .acc_valid (acc_valid),
    .acc_frame (acc_frame),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .vic_valid (vic_valid),
    .vic_ready (vic_ready),
    .vic_frame (vic_frame),
    .clr_en    (clr_en),
    .clr_idx   (clr_idx),
    .set_en    (set_en),
    .set_idx   (set_idx)
  );

  AST_FIRST_VICTIM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!rst_n) && rst_n) |-> (req_ready && !vic_valid)); // R1

endmodule

// File: tb/ref_victim_sel_test.sv
module ref_victim_sel_test;
  localparam int N  = 64;
  localparam int IW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_valid = 1'b0;
  logic [IW-1:0] acc_frame = '0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          vic_valid;
  logic          vic_ready = 1'b0;
  logic [IW-1:0] vic_frame;

  int errors = 0;
  int checks = 0;
  bit bg_on  = 1'b0;

  always #5 clk = ~clk;

  ref_victim_sel #(.NUM_FRAMES(N), .IDX_W(IW)) uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_frame(acc_frame),
    .req_valid(req_valid), .req_ready(req_ready), .vic_valid(vic_valid),
    .vic_ready(vic_ready), .vic_frame(vic_frame)
  );

  // Reference model of the requirements: 0 idle, 1 walking, 2 holding.
  logic [N-1:0] m_bits;
  int m_ptr, m_st, m_vic;

  function automatic int wrap(input int i);
    return (i + 1) % N;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_bits = '0; m_ptr = 0; m_st = 0; m_vic = 0;
    end else begin
      logic [N-1:0] nb;
      nb = m_bits;
      case (m_st)
        0: if (req_valid) m_st = 1;
        1: begin
          if (!(m_bits[m_ptr] || (acc_valid && int'(acc_frame) == m_ptr))) begin
            m_vic = m_ptr; m_st = 2;
          end else begin
            nb[m_ptr] = 1'b0; m_ptr = wrap(m_ptr);
          end
        end
        default: if (vic_ready) begin
          nb[m_vic] = 1'b1; m_ptr = wrap(m_vic); m_st = 0;
        end
      endcase
      if (acc_valid) nb[acc_frame] = 1'b1;
      m_bits = nb;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Model comparison every cycle (R3, R9 handshake and victim index).
  always @(negedge clk) begin
    if (bg_on && rst_n) begin
      chk(req_ready == (m_st == 0), "R9 req_ready vs model", int'(req_ready), int'(m_st == 0));
      chk(vic_valid == (m_st == 2), "R9 vic_valid vs model", int'(vic_valid), int'(m_st == 2));
      if (vic_valid && m_st == 2)
        chk(int'(vic_frame) == m_vic, "R3 vic_frame vs model", int'(vic_frame), m_vic);
    end
  end

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic touch(input int f);
    acc_valid = 1'b1; acc_frame = IW'(f);
    tick();
    acc_valid = 1'b0;
  endtask

  task automatic ask(input int hit_first, output int idx, output int cyc);
    req_valid = 1'b1;
    tick();
    req_valid = 1'b0;
    cyc = 0;
    if (hit_first >= 0) begin
      acc_valid = 1'b1; acc_frame = IW'(hit_first);
      tick(); cyc++;
      acc_valid = 1'b0;
    end
    while (!vic_valid && cyc < 3 * N) begin
      tick(); cyc++;
    end
    idx = int'(vic_frame);
  endtask

  task automatic take();
    vic_ready = 1'b1;
    tick();
    vic_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int v, c;
    void'($urandom(32'd1234));
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    bg_on = 1'b1;

    // R1: reset state and first victim
    chk(req_ready == 1'b1, "R1 req_ready after reset", int'(req_ready), 1);
    chk(vic_valid == 1'b0, "R1 vic_valid after reset", int'(vic_valid), 0);
    ask(-1, v, c);
    chk(v == 0, "R1 first victim", v, 0);
    chk(c == 1, "R1 latency first victim", c, 1);
    take();
    chk(req_ready == 1'b1, "R8 req_ready after handover", int'(req_ready), 1);

    // R2, R4: accessed frames 1..3 are passed over
    for (int f = 1; f <= 3; f++) touch(f);
    ask(-1, v, c);
    chk(v == 4, "R2 accessed frames skipped", v, 4);
    chk(c == 4, "R4 one frame per clock", c, 4);
    take();

    // R5: next walk starts after last victim
    ask(-1, v, c);
    chk(v == 5, "R5 resume after victim", v, 5);
    take();

    // R6, R4: all bits set, full sweep returns to the start frame
    for (int f = 0; f < N; f++) touch(f);
    ask(-1, v, c);
    chk(v == 6, "R4 cleared on pass, second pass chooses", v, 6);
    chk(c == N + 1, "R6 full-sweep latency", c, N + 1);
    take();

    // R9: result held under back-pressure, request refused
    ask(-1, v, c);
    chk(v == 7, "R9 held victim index", v, 7);
    req_valid = 1'b1;
    for (int k = 0; k < 5; k++) begin
      tick();
      chk(vic_valid == 1'b1, "R9 vic_valid held", int'(vic_valid), 1);
      chk(int'(vic_frame) == 7, "R9 vic_frame stable", int'(vic_frame), 7);
      chk(req_ready == 1'b0, "R9 req_ready low while pending", int'(req_ready), 0);
    end
    req_valid = 1'b0;
    take();

    // R8, R5 wrap: victim 7 bit set by handover, everything else accessed
    for (int f = 8; f < N; f++) touch(f);
    for (int f = 0; f < 7; f++) touch(f);
    ask(-1, v, c);
    chk(v == 8, "R8 handover set victim bit", v, 8);
    take();

    // R7: access to frame 9 in the cycle it is cleared keeps it set
    for (int f = 0; f < N; f++) touch(f);
    ask(9, v, c);
    chk(v == 10, "R7 access wins over clear", v, 10);
    take();

    // Random phase checked against the model every cycle.
    for (int k = 0; k < 6000; k++) begin
      acc_valid = ($urandom % 4) != 0;
      acc_frame = IW'((($urandom % 2) != 0) ? ($urandom % 8) : ($urandom % N));
      req_valid = ($urandom % 3) == 0;
      vic_ready = ($urandom % 2) != 0;
      tick();
    end
    acc_valid = 1'b0; req_valid = 1'b0; vic_ready = 1'b0;
    tick();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule